// File: doc/BRIEF.md
# BISYNC Transmit Character Framer

This block turns buffers of bytes into the character stream of a byte-synchronous link. Buffers arrive on a valid/ready byte stream. The first byte of each buffer carries that buffer's control flags. Characters leave on a second valid/ready stream toward a serializer. The serializer is expected to pull one character per character time. When no data is ready, the framer supplies idle or fill characters, so its output never runs dry after reset.

Each buffer selects the following:
- the normal or transparent mode;
- whether a DLE is sent ahead of it;
- whether the check accumulator is cleared before it;
- whether its characters are folded into the accumulator;
- whether it closes a message.

In transparent mode the framer does three things. It doubles every data DLE, it fills gaps with DLE-SYNC pairs, and it uses CRC16 whatever the configured check type. When a buffer that closes a message has been sent, the framer sends the check bytes and returns to plain SYNC idle. A status pulse reports the end of each buffer, together with an underrun flag for that buffer. The SYNC and DLE character codes and the check type are static configuration inputs.

Input back-pressure works as follows. `in_ready` is high only in a cycle in which the framer takes a data byte into its output register. A byte is accepted on a rising edge where `in_valid` and `in_ready` are both high. The producer must hold a byte and its flags until that byte is accepted.

Output back-pressure works as follows. The character in the output register is transferred on a rising edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_data` holds its value and no input is taken.

Top module: `bsc_tx_framer`

## Requirements
- R1: After reset, `out_valid` stays high. While no buffer is offered and nothing else is pending, every character sent is the SYNC code `cfg_sync`.
- R2: Buffer bytes are sent in order, each exactly once. `in_ready` is high only while the output register is free to load (`out_ready` high or `out_valid` low), and is low whenever `in_valid` is low.
- R3: A buffer whose `in_tx_dle` flag is set is preceded by exactly one `cfg_dle` character, sent before its first byte. That DLE is never folded into the check accumulator.
- R4: In a transparent buffer, every data byte equal to `cfg_dle` is followed directly by one extra `cfg_dle`. Only the data byte is accumulated.
- R5: In normal mode, an output slot that finds no byte offered and nothing pending is filled with `cfg_sync`.
- R6: In transparent mode, a gap is filled with whole `cfg_dle`,`cfg_sync` pairs, and a started pair is always completed before data resumes. The mode in force is the one named by the most recently started buffer.
- R7: When `in_bcs_rst` is set on a buffer's first byte, the accumulator is cleared before that buffer. When the flag is clear, the accumulator carries over from earlier buffers, including earlier messages. Reset clears it to zero.
- R8: Only the bytes of buffers with `in_bcs_en` set change the accumulator. The bytes of other buffers are sent unchanged.
- R9: CRC16 uses the polynomial x^16+x^15+x^2+1, processed LSB-first per byte (reflected constant 0xA001). After the closing buffer it is sent as two bytes, low byte first. It is used whenever `cfg_lrc` is 0 or the buffer is transparent.
- R10: With `cfg_lrc` = 1 and a normal buffer, the check is the XOR of the accumulated bytes, sent as one byte after the closing buffer.
- R11: One cycle after the last byte of a buffer (`in_last`) is accepted, `done_valid` pulses for one cycle. `done_underrun` is high with it exactly when a fill was sent between that buffer's first and last bytes.
- R12: After the check bytes of a closing buffer, the framer returns to normal mode. Idle is then SYNC only, even after a transparent message.
- R13: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sync | input | 8 | SYNC character code |
| cfg_dle | input | 8 | DLE character code |
| cfg_lrc | input | 1 | 1 selects LRC for normal buffers, 0 selects CRC16 |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte taken on this edge |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | Byte is the first of a buffer; flags are sampled with it |
| in_last | input | 1 | Byte is the last of a buffer |
| in_tx_dle | input | 1 | Send one DLE before this buffer |
| in_bcs_rst | input | 1 | Clear the accumulator before this buffer |
| in_bcs_en | input | 1 | Fold this buffer's bytes into the accumulator |
| in_transp | input | 1 | Buffer uses transparent mode |
| in_end_msg | input | 1 | Buffer closes the message; check bytes follow it |
| out_valid | output | 1 | Output character valid |
| out_ready | input | 1 | Serializer takes the character on this edge |
| out_data | output | 8 | Output character |
| done_valid | output | 1 | One-cycle pulse at the end of a buffer |
| done_underrun | output | 1 | Underrun flag for the buffer that just ended |

## Verification
A character is chosen on the edge that loads the output register. It is seen on `out_data` one cycle later and leaves on the first edge after that with `out_ready` high. The buffer status pulse comes exactly one cycle after the edge that accepts a last byte. The bench samples all outputs just before each rising edge. It logs a character only on a real transfer and logs status only while the pulse is high, so latency and stalls do not change the compared sequence. The number of fill characters in a gap depends on timing, so the bench checks the fill pattern and that at least one fill occurs, not an exact count.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  // Which source feeds the next output character, in priority order.
  typedef enum logic [2:0] {
    SEL_DUP,   // second DLE of a doubled data DLE
    SEL_PAIR,  // SYNC half of a transparent fill pair
    SEL_BCS,   // check sequence byte
    SEL_LEAD,  // DLE placed ahead of a buffer
    SEL_DATA,  // buffer byte
    SEL_FILL   // idle or underrun fill
  } slot_sel_t;

endpackage

// File: rtl/bsc_bcs_accum.sv
module bsc_bcs_accum #(
  parameter int DW = 8,
  parameter int CW = 16,
  parameter logic [CW-1:0] POLY = 16'hA001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fold,
  input  logic          use_crc,
  input  logic [DW-1:0] din,
  output logic [CW-1:0] acc
);

  logic [CW-1:0] acc_q;
  logic [CW-1:0] start;
  logic [CW-1:0] nxt;

  function automatic logic [CW-1:0] crc_step(input logic [CW-1:0] c_in,
                                             input logic [DW-1:0] d);
    logic [CW-1:0] c;
    c = c_in;
    for (int k = 0; k < DW; k++) begin
      if (c[0] ^ d[k]) c = (c >> 1) ^ POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction

  always_comb begin
    start = clr ? '0 : acc_q;
    nxt   = start;
    if (fold) begin
      if (use_crc) nxt = crc_step(start, din);
      else         nxt = {start[CW-1:DW], start[DW-1:0] ^ din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           acc_q <= '0;
    else if (clr || fold) acc_q <= nxt;
  end

  assign acc = acc_q;

endmodule

// File: rtl/bsc_urun_track.sv
module bsc_urun_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_first,
  input  logic take_last,
  input  logic fill_in_buf,
  output logic done_valid,
  output logic done_underrun
);

  logic urun_q;
  logic dv_q;
  logic du_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      urun_q <= 1'b0;
      dv_q   <= 1'b0;
      du_q   <= 1'b0;
    end else begin
      dv_q <= take & take_last;
      if (take && take_last) begin
        du_q   <= take_first ? 1'b0 : urun_q;
        urun_q <= 1'b0;
      end else if (take && take_first) begin
        urun_q <= 1'b0;
      end else if (fill_in_buf) begin
        urun_q <= 1'b1;
      end
    end
  end

  assign done_valid    = dv_q;
  assign done_underrun = du_q & dv_q;

endmodule

// File: rtl/bsc_tx_seq.sv
module bsc_tx_seq
  import bsc_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cfg_sync,
  input  logic [DW-1:0] cfg_dle,
  input  logic          cfg_lrc,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_first,
  input  logic          in_last,
  input  logic          in_tx_dle,
  input  logic          in_bcs_rst,
  input  logic          in_bcs_en,
  input  logic          in_transp,
  input  logic          in_end_msg,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic [CW-1:0] acc,
  output logic          acc_clr,
  output logic          acc_fold,
  output logic          acc_crc,
  output logic [DW-1:0] acc_din,
  output logic          take,
  output logic          fill_in_buf
);

  localparam int BCS_N = CW / DW;
  localparam int BCS_W = $clog2(BCS_N + 1);

  logic          ov_q;
  logic [DW-1:0] oq;
  logic          busy_q, mode_tp_q, lead_done_q, dup_q, pair_q;
  logic          cur_tp_q, cur_en_q, cur_end_q;
  logic [BCS_W-1:0] bcs_left_q, bcs_tot_q, bcs_idx;
  logic [CW-1:0] bcs_sh;

  slot_sel_t     sel;
  logic          load;
  logic          tp_eff, en_eff, end_eff, crc_eff;
  logic [DW-1:0] ch;

  // Flags come with the first byte; later bytes use the latched copy.
  always_comb begin
    tp_eff  = in_first ? in_transp  : cur_tp_q;
    en_eff  = in_first ? in_bcs_en  : cur_en_q;
    end_eff = in_first ? in_end_msg : cur_end_q;
    crc_eff = tp_eff | ~cfg_lrc;
  end

  always_comb begin
    if (dup_q)                                          sel = SEL_DUP;
    else if (pair_q)                                    sel = SEL_PAIR;
    else if (bcs_left_q != '0)                          sel = SEL_BCS;
    else if (in_valid && in_first && in_tx_dle && !lead_done_q) sel = SEL_LEAD;
    else if (in_valid)                                  sel = SEL_DATA;
    else                                                sel = SEL_FILL;
  end

  assign bcs_idx = bcs_tot_q - bcs_left_q;
  assign bcs_sh  = acc >> (DW * int'(bcs_idx));

  always_comb begin
    unique case (sel)
      SEL_DUP:  ch = cfg_dle;
      SEL_PAIR: ch = cfg_sync;
      SEL_BCS:  ch = bcs_sh[DW-1:0];
      SEL_LEAD: ch = cfg_dle;
      SEL_DATA: ch = in_data;
      default:  ch = mode_tp_q ? cfg_dle : cfg_sync;
    endcase
  end

  assign load        = ~ov_q | out_ready;
  assign in_ready    = load & (sel == SEL_DATA);
  assign take        = in_ready;
  assign acc_clr     = take & in_first & in_bcs_rst;
  assign acc_fold    = take & en_eff;
  assign acc_crc     = crc_eff;
  assign acc_din     = in_data;
  assign fill_in_buf = load & (sel == SEL_FILL) & busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q        <= 1'b0;
      oq          <= '0;
      busy_q      <= 1'b0;
      mode_tp_q   <= 1'b0;
      lead_done_q <= 1'b0;
      dup_q       <= 1'b0;
      pair_q      <= 1'b0;
      cur_tp_q    <= 1'b0;
      cur_en_q    <= 1'b0;
      cur_end_q   <= 1'b0;
      bcs_left_q  <= '0;
      bcs_tot_q   <= '0;
    end else if (load) begin
      ov_q <= 1'b1;
      oq   <= ch;
      unique case (sel)
        SEL_DUP:  dup_q  <= 1'b0;
        SEL_PAIR: pair_q <= 1'b0;
        SEL_BCS: begin
          bcs_left_q <= bcs_left_q - BCS_W'(1);
          if (bcs_left_q == BCS_W'(1)) mode_tp_q <= 1'b0;
        end
        SEL_LEAD: lead_done_q <= 1'b1;
        SEL_DATA: begin
          lead_done_q <= 1'b0;
          if (in_first) begin
            cur_tp_q  <= in_transp;
            cur_en_q  <= in_bcs_en;
            cur_end_q <= in_end_msg;
            mode_tp_q <= in_transp;
          end
          dup_q  <= tp_eff & (in_data == cfg_dle);
          busy_q <= ~in_last;
          if (in_last && end_eff) begin
            bcs_left_q <= crc_eff ? BCS_W'(BCS_N) : BCS_W'(1);
            bcs_tot_q  <= crc_eff ? BCS_W'(BCS_N) : BCS_W'(1);
          end
        end
        default: pair_q <= mode_tp_q;
      endcase
    end
  end

  assign out_valid = ov_q;
  assign out_data  = oq;

endmodule

// File: rtl/bsc_tx_framer.sv
module bsc_tx_framer #(
  parameter int DW = 8,
  parameter int CW = 16,
  parameter logic [CW-1:0] POLY = 16'hA001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cfg_sync,
  input  logic [DW-1:0] cfg_dle,
  input  logic          cfg_lrc,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_first,
  input  logic          in_last,
  input  logic          in_tx_dle,
  input  logic          in_bcs_rst,
  input  logic          in_bcs_en,
  input  logic          in_transp,
  input  logic          in_end_msg,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          done_valid,
  output logic          done_underrun
);

  logic [CW-1:0] acc;
  logic          acc_clr, acc_fold, acc_crc;
  logic [DW-1:0] acc_din;
  logic          take, fill_in_buf;

  bsc_tx_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_sync(cfg_sync), .cfg_dle(cfg_dle), .cfg_lrc(cfg_lrc),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .in_tx_dle(in_tx_dle),
    .in_bcs_rst(in_bcs_rst), .in_bcs_en(in_bcs_en),
    .in_transp(in_transp), .in_end_msg(in_end_msg),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .acc(acc), .acc_clr(acc_clr), .acc_fold(acc_fold),
    .acc_crc(acc_crc), .acc_din(acc_din),
    .take(take), .fill_in_buf(fill_in_buf)
  );

  bsc_bcs_accum #(.DW(DW), .CW(CW), .POLY(POLY)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .clr(acc_clr), .fold(acc_fold), .use_crc(acc_crc),
    .din(acc_din), .acc(acc)
  );

  bsc_urun_track u_urun (
    .clk(clk), .rst_n(rst_n),
    .take(take), .take_first(in_first), .take_last(in_last),
    .fill_in_buf(fill_in_buf),
    .done_valid(done_valid), .done_underrun(done_underrun)
  );

endmodule

// File: rtl/bsc_tx_framer_chk.sv
module bsc_tx_framer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          done_valid,
  input logic          done_underrun
);

  assert_out_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid);

  assert_ready_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (in_valid && (out_ready || !out_valid)));

  assert_stall_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(in_valid && in_ready && in_last));

  assert_urun_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_underrun |-> done_valid);

endmodule

bind bsc_tx_framer bsc_tx_framer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .done_valid(done_valid), .done_underrun(done_underrun)
);

// File: tb/tb_bsc_tx_framer.sv
`timescale 1ns/1ps
module tb_bsc_tx_framer;

  localparam logic [7:0] SYNC = 8'h32;
  localparam logic [7:0] DLE  = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_lrc = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic in_tx_dle = 1'b0, in_bcs_rst = 1'b0, in_bcs_en = 1'b0;
  logic in_transp = 1'b0, in_end_msg = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_ready, done_valid, done_underrun;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  bsc_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .cfg_sync(SYNC), .cfg_dle(DLE), .cfg_lrc(cfg_lrc),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .in_tx_dle(in_tx_dle),
    .in_bcs_rst(in_bcs_rst), .in_bcs_en(in_bcs_en), .in_transp(in_transp),
    .in_end_msg(in_end_msg), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done_valid(done_valid), .done_underrun(done_underrun)
  );

  int checks = 0, fails = 0, stall_err = 0;
  bit finished = 0;
  bit rdy_rand = 0;

  logic [7:0] cap[$];
  bit done_q[$];
  logic [7:0] exp_q[$];
  int exp_gap;
  bit exp_gap_tp;

  logic [7:0] mdat[$];
  logic [7:0] stg[$];
  int blen[$];
  bit ftx[$], frs[$], fen[$], ftp[$];
  logic [15:0] macc = 16'h0000;
  int gbuf = -1, gpos = 0, glen = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) out_ready <= rdy_rand ? (($urandom % 4) != 0) : 1'b1;

  logic [7:0] prev_d;
  bit prev_stall = 0;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_stall && (out_data !== prev_d || out_valid !== 1'b1)) stall_err++;
      prev_stall = out_valid && !out_ready;
      prev_d = out_data;
      if (out_valid && out_ready) cap.push_back(out_data);
      if (done_valid) done_q.push_back(done_underrun);
    end
  end

  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [7:0] d);
    for (int k = 0; k < 8; k++) begin
      if (c[0] ^ d[k]) c = (c >> 1) ^ 16'hA001;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic clear_msg();
    mdat.delete(); blen.delete(); ftx.delete(); frs.delete();
    fen.delete(); ftp.delete(); gbuf = -1; gpos = 0; glen = 0;
  endtask

  task automatic add_buf(bit tx, bit rs, bit en, bit tp);
    ftx.push_back(tx); frs.push_back(rs); fen.push_back(en); ftp.push_back(tp);
    blen.push_back(stg.size());
    foreach (stg[k]) mdat.push_back(stg[k]);
    stg.delete();
  endtask

  task automatic build();
    int p = 0;
    int nb = blen.size();
    bit crc;
    exp_q.delete(); exp_gap = -1; exp_gap_tp = 0;
    for (int b = 0; b < nb; b++) begin
      for (int i = 0; i < blen[b]; i++) begin
        logic [7:0] d = mdat[p + i];
        if (i == 0) begin
          if (b == gbuf && b > 0) begin exp_gap = exp_q.size(); exp_gap_tp = ftp[b-1]; end
          if (ftx[b]) exp_q.push_back(DLE);
          if (frs[b]) macc = 16'h0000;
        end else if (b == gbuf && i == gpos) begin
          exp_gap = exp_q.size(); exp_gap_tp = ftp[b];
        end
        exp_q.push_back(d);
        if (ftp[b] && d == DLE) exp_q.push_back(DLE);
        if (fen[b]) begin
          if (ftp[b] || !cfg_lrc) macc = ref_crc(macc, d);
          else macc = {macc[15:8], macc[7:0] ^ d};
        end
      end
      p += blen[b];
    end
    crc = ftp[nb-1] || !cfg_lrc;
    exp_q.push_back(macc[7:0]);
    if (crc) exp_q.push_back(macc[15:8]);
  endtask

  task automatic send_msg();
    int p = 0;
    int nb = blen.size();
    for (int b = 0; b < nb; b++) begin
      for (int i = 0; i < blen[b]; i++) begin
        if (b == gbuf && i == gpos) begin
          @(negedge clk); in_valid = 1'b0;
          repeat (glen) @(negedge clk);
        end else begin
          @(negedge clk);
        end
        in_valid = 1'b1; in_data = mdat[p + i];
        in_first = (i == 0); in_last = (i == blen[b] - 1);
        in_tx_dle = ftx[b]; in_bcs_rst = frs[b]; in_bcs_en = fen[b];
        in_transp = ftp[b]; in_end_msg = (b == nb - 1);
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk);
      end
      p += blen[b];
    end
    @(negedge clk); in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_msg(string tag, string gtag, bit rr);
    int i = 0, nf = 0, act = -1, at = -1;
    bit ok = 1;
    cap.delete(); done_q.delete();
    build();
    rdy_rand = rr;
    send_msg();
    repeat (40) @(negedge clk);
    rdy_rand = 0;
    while (i < cap.size() && cap[i] == SYNC) i++;
    for (int k = 0; k < exp_q.size(); k++) begin
      if (k == exp_gap) begin
        nf = 0;
        if (exp_gap_tp) begin
          while (i + 1 < cap.size() && cap[i] == DLE && cap[i+1] == SYNC) begin i += 2; nf++; end
        end else begin
          while (i < cap.size() && cap[i] == SYNC) begin i++; nf++; end
        end
        chk(nf > 0, gtag, "fill units in gap", nf, 1);
      end
      if (i >= cap.size() || cap[i] !== exp_q[k]) begin
        ok = 0; at = k; act = (i < cap.size()) ? int'(cap[i]) : -1;
        break;
      end
      i++;
    end
    chk(ok, tag, $sformatf("stream char %0d", at), act, (at >= 0) ? int'(exp_q[at]) : 0);
    chk(i + 1 < cap.size() && cap[i] == SYNC && cap[i+1] == SYNC, "R1 R12", "idle after message",
        (i < cap.size()) ? int'(cap[i]) : -1, SYNC);
    chk(done_q.size() == blen.size(), "R11", "status pulses", done_q.size(), blen.size());
    foreach (done_q[b])
      chk(done_q[b] == (b == gbuf && gpos > 0), "R11", "underrun flag",
          done_q[b], (b == gbuf && gpos > 0));
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid == 1'b1, "R1", "out_valid after reset", out_valid, 1);
    chk(out_data == SYNC, "R1", "idle char after reset", out_data, SYNC);
    chk(in_ready == 1'b0, "R2", "in_ready with no input", in_ready, 0);
    chk(done_valid == 1'b0, "R11", "no status after reset", done_valid, 0);

    // R9: CRC16 on a normal buffer
    cfg_lrc = 0; clear_msg();
    stg = '{8'h41, 8'h42, 8'h43}; add_buf(0, 1, 1, 0);
    run_msg("R2 R9", "R5", 0);
    // R10: LRC on a normal buffer
    cfg_lrc = 1; clear_msg();
    stg = '{8'h41, 8'h42, 8'h43}; add_buf(0, 1, 1, 0);
    run_msg("R10", "R5", 0);
    // R4 and R9: transparent doubling, CRC forced despite LRC config
    cfg_lrc = 1; clear_msg();
    stg = '{8'h10, 8'h55, 8'h10, 8'h10, 8'h03}; add_buf(1, 1, 1, 1);
    run_msg("R3 R4 R9", "R6", 1);
    // R3: leading DLE on a normal buffer
    cfg_lrc = 0; clear_msg();
    stg = '{8'h02, 8'h61}; add_buf(1, 1, 1, 0);
    run_msg("R3", "R5", 0);
    // R8 and R7: excluded buffer then included buffer without reset
    cfg_lrc = 0; clear_msg();
    stg = '{8'h01, 8'h99}; add_buf(0, 1, 0, 0);
    stg = '{8'h77, 8'h10}; add_buf(0, 0, 1, 0);
    run_msg("R7 R8", "R5", 1);
    // R7: carry over from the previous message
    cfg_lrc = 0; clear_msg();
    stg = '{8'h5A}; add_buf(0, 0, 1, 0);
    run_msg("R7", "R5", 0);
    // R5 and R11: normal gap inside a buffer
    cfg_lrc = 0; clear_msg();
    stg = '{8'h41, 8'h42, 8'h43, 8'h44}; add_buf(0, 1, 1, 0);
    gbuf = 0; gpos = 2; glen = 5;
    run_msg("R5 R11", "R5", 0);
    // R6 and R11: transparent gap inside a buffer
    cfg_lrc = 0; clear_msg();
    stg = '{8'h10, 8'h41, 8'h10, 8'h42}; add_buf(0, 1, 1, 1);
    gbuf = 0; gpos = 2; glen = 6;
    run_msg("R6 R11", "R6", 0);
    // R6 and R12: gap between transparent buffers, then SYNC idle
    cfg_lrc = 1; clear_msg();
    stg = '{8'h41, 8'h42}; add_buf(0, 1, 1, 1);
    stg = '{8'h43}; add_buf(0, 0, 1, 1);
    gbuf = 1; gpos = 0; glen = 5;
    run_msg("R6 R12", "R6", 0);

    // Random messages with output back-pressure
    for (int m = 0; m < 30; m++) begin
      int nb = 1 + ($urandom % 3);
      cfg_lrc = $urandom % 2;
      clear_msg();
      for (int b = 0; b < nb; b++) begin
        bit tx = $urandom % 2;
        int ln = 1 + ($urandom % 6);
        for (int k = 0; k < ln; k++) begin
          logic [7:0] d = (($urandom % 4) == 0) ? DLE : 8'($urandom);
          if (b == 0 && k == 0 && !tx && d == SYNC) d = 8'h5C;
          stg.push_back(d);
        end
        add_buf(tx, $urandom % 2, $urandom % 2, $urandom % 2);
      end
      run_msg("R2 R3 R4 R7 R8 R9 R10", "R5", 1);
    end
    chk(stall_err == 0, "R13", "output held under stall", stall_err, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule